// File: doc/BRIEF.md
# Store-to-Load Overlap Detector

This block sits beside an instruction grouping stage. It flags a load that would read bytes written by a store earlier in the same dispatch group. The stage strobes each accepted store into the detector. The detector keeps the two address operands and the access size of the most recent store only. Every later load candidate is then compared against that record, and the result is a single combinational hit flag in the same cycle. A group-close strobe empties the record.

The comparison works on operand tags, not on resolved addresses. Each address is written as two operands. Each operand carries a 16-bit value and a flag that tells whether the value is a register identifier or a signed constant offset. A hit is raised in two cases:
- both operands of the load equal those of the store, in either order;
- the second operands are equal, both first operands are constants, and the two byte ranges intersect.

Top module: `st_ld_overlap`

## Requirements
- R1: After reset no store is recorded, and `ld_hit` is 0 for any load.
- R2: A load whose first and second operands (value and constant flag) equal those of the recorded store raises `ld_hit`.
- R3: A load whose operands equal the recorded store's operands in swapped order (load first = store second, load second = store first) raises `ld_hit`.
- R4: When the second operands are equal and both first operands are constants, with the store offset below the load offset, `ld_hit` is 1 exactly when store offset + store bytes > load offset.
- R5: In the same shared-second-operand case with the store offset at or above the load offset, `ld_hit` is 1 exactly when load offset + load bytes > store offset. Equal offsets always hit.
- R6: The 2-bit size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes for both stores and loads.
- R7: With no store recorded, `ld_hit` stays 0 even for a load that matches the last store's operands.
- R8: A `grp_close` pulse without `st_accept` empties the record from the next cycle on.
- R9: A new `st_accept` replaces the recorded store. Only the newest store is compared.
- R10: When `st_accept` and `grp_close` occur in the same cycle, the store is recorded as the first entry of the new group.
- R11: `ld_hit` is combinational and is 0 whenever `ld_valid` is 0.
- R12: A constant and a register operand with the same value never count as equal. Offsets are signed 16-bit values, sign-extended to 18 bits for the range arithmetic, so negative offsets compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_accept | input | 1 | Record the store presented this cycle |
| grp_close | input | 1 | Close the current dispatch group |
| st_a_val | input | 16 | Store first operand value |
| st_a_imm | input | 1 | Store first operand is a constant |
| st_b_val | input | 16 | Store second operand value |
| st_b_imm | input | 1 | Store second operand is a constant |
| st_size | input | 2 | Store size code (1/2/4/8 bytes) |
| ld_valid | input | 1 | A load candidate is presented |
| ld_a_val | input | 16 | Load first operand value |
| ld_a_imm | input | 1 | Load first operand is a constant |
| ld_b_val | input | 16 | Load second operand value |
| ld_b_imm | input | 1 | Load second operand is a constant |
| ld_size | input | 2 | Load size code (1/2/4/8 bytes) |
| ld_hit | output | 1 | Load overlaps the recorded store |

## Verification
All of the block's state is the store record, and it reaches the ports through `ld_hit` one cycle after the strobe that wrote it. Some faults leave stale contents behind: a lost clear, or a dropped or wrong update. These show up on the first load probed after the strobe, as a hit where none is due or as a missed hit. A size code decoded wrongly, or a sign extension that is missing, shows up only on a load placed at the edge of the byte range. For that reason the probes sit one byte inside and one byte outside each range boundary, including the negative offsets.

// File: rtl/sldo_pkg.sv
package sldo_pkg;
  localparam int BYTES_W = 4;

  // Access size code to byte count: 0->1, 1->2, 2->4, 3->8
  function automatic logic [BYTES_W-1:0] size_to_bytes(input logic [1:0] code);
    logic [BYTES_W-1:0] b;
    case (code)
      2'd0:    b = 4'd1;
      2'd1:    b = 4'd2;
      2'd2:    b = 4'd4;
      default: b = 4'd8;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/sldo_store_reg.sv
module sldo_store_reg #(
  parameter int OPW     = 17,
  parameter int BYTES_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               close,
  input  logic [OPW-1:0]     a_in,
  input  logic [OPW-1:0]     b_in,
  input  logic [BYTES_W-1:0] bytes_in,
  output logic [OPW-1:0]     rec_a,
  output logic [OPW-1:0]     rec_b,
  output logic [BYTES_W-1:0] rec_bytes
);
  logic [OPW-1:0]     a_nxt, b_nxt;
  logic [BYTES_W-1:0] bytes_nxt;
  logic               upd_en;

  assign upd_en = accept | close;

  // Accept wins over close: the store opens the new group.
  always_comb begin
    a_nxt     = rec_a;
    b_nxt     = rec_b;
    bytes_nxt = rec_bytes;
    if (accept) begin
      a_nxt     = a_in;
      b_nxt     = b_in;
      bytes_nxt = bytes_in;
    end else if (close) begin
      bytes_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_a     <= '0;
      rec_b     <= '0;
      rec_bytes <= '0;
    end else if (upd_en) begin
      rec_a     <= a_nxt;
      rec_b     <= b_nxt;
      rec_bytes <= bytes_nxt;
    end
  end

  assert_close_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !accept) |=> (rec_bytes == '0));
  assert_accept_records_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rec_bytes == $past(bytes_in)) && (rec_a == $past(a_in)) && (rec_b == $past(b_in)));
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !close) |=> $stable(rec_bytes) && $stable(rec_a) && $stable(rec_b));
endmodule

// File: rtl/sldo_range_cmp.sv
module sldo_range_cmp #(
  parameter int VAL_W   = 16,
  parameter int BYTES_W = 4
) (
  input  logic [VAL_W-1:0]   st_off,
  input  logic [VAL_W-1:0]   ld_off,
  input  logic [BYTES_W-1:0] st_bytes,
  input  logic [BYTES_W-1:0] ld_bytes,
  output logic               overlap
);
  localparam int EXT_W = VAL_W + 2;

  logic signed [EXT_W-1:0] so, lo, ss, ls, st_end, ld_end;

  always_comb begin
    so     = EXT_W'(signed'(st_off));
    lo     = EXT_W'(signed'(ld_off));
    ss     = signed'({{(EXT_W-BYTES_W){1'b0}}, st_bytes});
    ls     = signed'({{(EXT_W-BYTES_W){1'b0}}, ld_bytes});
    st_end = so + ss;
    ld_end = lo + ls;
    if (so < lo) overlap = (st_end > lo);
    else         overlap = (ld_end > so);
  end

  assert_same_offset_overlaps_R5: assert final (
    !((st_off == ld_off) && (ld_bytes != '0)) || overlap);
endmodule

// File: rtl/st_ld_overlap.sv
module st_ld_overlap #(
  parameter int VAL_W = 16,
  parameter int SZ_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_accept,
  input  logic             grp_close,
  input  logic [VAL_W-1:0] st_a_val,
  input  logic             st_a_imm,
  input  logic [VAL_W-1:0] st_b_val,
  input  logic             st_b_imm,
  input  logic [SZ_W-1:0]  st_size,
  input  logic             ld_valid,
  input  logic [VAL_W-1:0] ld_a_val,
  input  logic             ld_a_imm,
  input  logic [VAL_W-1:0] ld_b_val,
  input  logic             ld_b_imm,
  input  logic [SZ_W-1:0]  ld_size,
  output logic             ld_hit
);
  import sldo_pkg::*;

  localparam int OPW = VAL_W + 1;

  logic [OPW-1:0]     st_a, st_b, ld_a, ld_b;
  logic [OPW-1:0]     rec_a, rec_b;
  logic [BYTES_W-1:0] rec_bytes, ld_bytes, st_bytes;
  logic               pending, same_order, swapped, shared_base, both_const;
  logic               range_ovl;

  // Operand tag: {is_constant, value}
  assign st_a     = {st_a_imm, st_a_val};
  assign st_b     = {st_b_imm, st_b_val};
  assign ld_a     = {ld_a_imm, ld_a_val};
  assign ld_b     = {ld_b_imm, ld_b_val};
  assign st_bytes = size_to_bytes(st_size);
  assign ld_bytes = size_to_bytes(ld_size);

  sldo_store_reg #(.OPW(OPW), .BYTES_W(BYTES_W)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (st_accept),
    .close    (grp_close),
    .a_in     (st_a),
    .b_in     (st_b),
    .bytes_in (st_bytes),
    .rec_a    (rec_a),
    .rec_b    (rec_b),
    .rec_bytes(rec_bytes)
  );

  sldo_range_cmp #(.VAL_W(VAL_W), .BYTES_W(BYTES_W)) u_range (
    .st_off  (rec_a[VAL_W-1:0]),
    .ld_off  (ld_a_val),
    .st_bytes(rec_bytes),
    .ld_bytes(ld_bytes),
    .overlap (range_ovl)
  );

  always_comb begin
    pending     = (rec_bytes != '0);
    same_order  = (ld_a == rec_a) && (ld_b == rec_b);
    swapped     = (ld_a == rec_b) && (ld_b == rec_a);
    shared_base = (ld_b == rec_b);
    both_const  = rec_a[VAL_W] && ld_a_imm;
    ld_hit      = ld_valid && pending &&
                  (same_order || swapped || (shared_base && both_const && range_ovl));
  end

  assert_no_hit_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_bytes == '0) |-> !ld_hit);
  assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> ld_valid);
  assert_legal_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rec_bytes));
  assert_empty_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rec_bytes == '0));
endmodule

// File: tb/st_ld_overlap_bench.sv
module st_ld_overlap_bench;
  logic        clk, rst_n;
  logic        st_accept, grp_close;
  logic [15:0] st_a_val, st_b_val, ld_a_val, ld_b_val;
  logic        st_a_imm, st_b_imm, ld_a_imm, ld_b_imm, ld_valid;
  logic [1:0]  st_size, ld_size;
  logic        ld_hit;
  int          total, bad;

  st_ld_overlap u_st_ld_overlap (
    .clk(clk), .rst_n(rst_n), .st_accept(st_accept), .grp_close(grp_close),
    .st_a_val(st_a_val), .st_a_imm(st_a_imm), .st_b_val(st_b_val), .st_b_imm(st_b_imm),
    .st_size(st_size), .ld_valid(ld_valid), .ld_a_val(ld_a_val), .ld_a_imm(ld_a_imm),
    .ld_b_val(ld_b_val), .ld_b_imm(ld_b_imm), .ld_size(ld_size), .ld_hit(ld_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: ld_hit=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic store(input logic aimm, input logic [15:0] a, input logic bimm,
                       input logic [15:0] b, input logic [1:0] sz, input logic cls);
    @(negedge clk);
    st_accept = 1'b1; grp_close = cls;
    st_a_imm = aimm; st_a_val = a; st_b_imm = bimm; st_b_val = b; st_size = sz;
    @(negedge clk);
    st_accept = 1'b0; grp_close = 1'b0;
  endtask

  task automatic close_group();
    @(negedge clk);
    grp_close = 1'b1;
    @(negedge clk);
    grp_close = 1'b0;
  endtask

  task automatic probe(input string req, input logic aimm, input logic [15:0] a,
                       input logic bimm, input logic [15:0] b, input logic [1:0] sz,
                       input logic exp);
    @(negedge clk);
    ld_valid = 1'b1; ld_a_imm = aimm; ld_a_val = a; ld_b_imm = bimm; ld_b_val = b; ld_size = sz;
    #1 chk(req, ld_hit, exp);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset();
    probe("R1", 1'b0, 16'd3, 1'b0, 16'd7, 2'd2, 1'b0);
    probe("R1", 1'b1, 16'd0, 1'b0, 16'd0, 2'd3, 1'b0);
  endtask

  task automatic t_exact();
    store(1'b0, 16'd3, 1'b0, 16'd7, 2'd2, 1'b0);
    probe("R2", 1'b0, 16'd3, 1'b0, 16'd7, 2'd2, 1'b1);
    probe("R3", 1'b0, 16'd7, 1'b0, 16'd3, 2'd2, 1'b1);
    probe("R2", 1'b0, 16'd3, 1'b0, 16'd8, 2'd2, 1'b0);
    probe("R12", 1'b1, 16'd3, 1'b0, 16'd7, 2'd2, 1'b0);
    // R11: matching operands, ld_valid low
    @(negedge clk);
    ld_valid = 1'b0; ld_a_imm = 1'b0; ld_a_val = 16'd3; ld_b_imm = 1'b0; ld_b_val = 16'd7;
    #1 chk("R11", ld_hit, 1'b0);
  endtask

  task automatic t_range_pos();
    // store [8..15] (code 3 = 8 bytes) on base reg 5
    store(1'b1, 16'd8, 1'b0, 16'd5, 2'd3, 1'b0);
    probe("R4", 1'b1, 16'd16, 1'b0, 16'd5, 2'd2, 1'b0);
    probe("R4", 1'b1, 16'd15, 1'b0, 16'd5, 2'd0, 1'b1);
    probe("R5", 1'b1, 16'd4, 1'b0, 16'd5, 2'd2, 1'b0);
    probe("R5", 1'b1, 16'd5, 1'b0, 16'd5, 2'd2, 1'b1);
    probe("R6", 1'b1, 16'd6, 1'b0, 16'd5, 2'd1, 1'b0);
    probe("R6", 1'b1, 16'd7, 1'b0, 16'd5, 2'd1, 1'b1);
    probe("R5", 1'b1, 16'd8, 1'b0, 16'd5, 2'd0, 1'b1);
    probe("R4", 1'b1, 16'd12, 1'b0, 16'd6, 2'd2, 1'b0);
  endtask

  task automatic t_range_neg();
    // store [-4..-1] (code 2 = 4 bytes)
    store(1'b1, 16'hFFFC, 1'b0, 16'd9, 2'd2, 1'b0);
    probe("R12", 1'b1, 16'd0, 1'b0, 16'd9, 2'd0, 1'b0);
    probe("R12", 1'b1, 16'hFFFF, 1'b0, 16'd9, 2'd0, 1'b1);
    probe("R12", 1'b1, 16'hFFFA, 1'b0, 16'd9, 2'd0, 1'b0);
    probe("R12", 1'b1, 16'hFFFA, 1'b0, 16'd9, 2'd1, 1'b0);
    probe("R12", 1'b1, 16'hFFFB, 1'b0, 16'd9, 2'd1, 1'b1);
  endtask

  task automatic t_replace_close();
    store(1'b0, 16'd1, 1'b0, 16'd2, 2'd2, 1'b0);
    store(1'b0, 16'd10, 1'b0, 16'd11, 2'd2, 1'b0);
    probe("R9", 1'b0, 16'd1, 1'b0, 16'd2, 2'd2, 1'b0);
    probe("R9", 1'b0, 16'd10, 1'b0, 16'd11, 2'd2, 1'b1);
    close_group();
    probe("R8", 1'b0, 16'd10, 1'b0, 16'd11, 2'd2, 1'b0);
    probe("R7", 1'b0, 16'd11, 1'b0, 16'd10, 2'd2, 1'b0);
    store(1'b0, 16'd20, 1'b0, 16'd21, 2'd0, 1'b1);
    probe("R10", 1'b0, 16'd20, 1'b0, 16'd21, 2'd0, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: ld_hit=%0b expected=done", ld_hit);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; st_accept = 1'b0; grp_close = 1'b0; ld_valid = 1'b0;
    st_a_val = '0; st_b_val = '0; st_a_imm = 1'b0; st_b_imm = 1'b0; st_size = '0;
    ld_a_val = '0; ld_b_val = '0; ld_a_imm = 1'b0; ld_b_imm = 1'b0; ld_size = '0;
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exact();
    t_range_pos();
    t_range_neg();
    t_replace_close();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule